// File: doc/BRIEF.md
# Dual-Core Time-Slice Scheduler

This block decides which of two processor cores may run at any moment, when the cores run at different clock rates. The fast core's clock is twice the slow core's. The active core sends one advance strobe for each of its own cycles. The scheduler counts those strobes against a slice budget. When the budget is used up, it hands execution to the other core.

Budgets are not fixed round-robin slices. A signed drift accumulator records how far the fast core has run ahead, measured in fast-core cycles. Each new budget comes from the drift, so over many slices the time seen by the two cores stays consistent.

The controller has two states:
- `ST_FAST`: the fast core runs.
- `ST_SLOW`: the slow core runs.

There are two transitions, and each fires on the strobe that uses up the budget:
- `T_TO_SLOW`: from `ST_FAST` to `ST_SLOW`.
- `T_TO_FAST`: from `ST_SLOW` to `ST_FAST`.

The elapsed count measures the slice since its start. It restarts at zero on every transition.

Top module: `slice_arbiter`

## Requirements
- R1: After reset the state is `ST_FAST`, the drift is 0, the budget is 2048 (parameter SLICE), `handover_o` is 0 and the elapsed count is zero. On `core_sel_o`, bit 0 means the fast core and bit 1 means the slow core, so this reads 2'b01.
- R2: `core_sel_o` always has exactly one bit set.
- R3: A transition happens on the strobe that brings the slice's strobe count up to the budget, and never earlier. The new core, drift and budget appear one clock after that strobe.
- R4: On `T_TO_SLOW`, the drift becomes drift + E, where E is the number of strobes in the slice just ended. The new budget is the new drift shifted arithmetically right by one.
- R5: On `T_TO_FAST`, the drift becomes drift − 2·E. The new budget is the new drift plus 2048.
- R6: `handover_o` is high for exactly one clock for each transition, in the same cycle the new core is first shown.
- R7: While `step_i` is low, the elapsed count, the active core and `handover_o` do not change; `handover_o` stays 0.
- R8: Drift arithmetic is signed. A computed budget below one is clamped to 1, so `budget_o` is never 0.
- R9: `drift_o` and `budget_o` change only in the cycle of a transition and hold steady within a slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One pulse per cycle of the active core |
| core_sel_o | output | 2 | One-hot active core: bit 0 is fast, bit 1 is slow |
| budget_o | output | 24 | Strobe budget of the current slice |
| drift_o | output | 32 | Signed drift accumulator, in fast-core cycles |
| handover_o | output | 1 | One-clock pulse on each change of core |

## Verification
The hardest case to reach from the ports is the exact boundary of a slice. The bench stops one strobe short of the budget while the strobes arrive with gaps, then confirms that no handover happens until the final strobe. To do this it keeps its own strobe count and its own drift model, and stalls in the middle of a slice for many idle cycles. A reset is also applied partway through a slice, to show that the elapsed count is cleared rather than carried into the next slice.

// File: rtl/slice_pkg.sv
package slice_pkg;
    typedef enum logic {
        ST_FAST = 1'b0,
        ST_SLOW = 1'b1
    } sched_state_t;
endpackage

// File: rtl/slice_counter.sv
module slice_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] elapsed_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] elapsed_q;
    logic [CNT_W:0]   next_cnt;

    assign next_cnt  = {1'b0, elapsed_q} + 1'b1;
    assign hit_o     = step_i && (next_cnt >= {1'b0, limit_i});
    assign elapsed_o = elapsed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (hit_o) begin
            elapsed_q <= '0;
        end else if (step_i) begin
            elapsed_q <= next_cnt[CNT_W-1:0];
        end
    end

    // R7: without a strobe the count holds
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(elapsed_q));
endmodule

// File: rtl/slice_budget_calc.sv
module slice_budget_calc #(
    parameter int CNT_W   = 24,
    parameter int DRIFT_W = 32,
    parameter int SLICE   = 2048
) (
    input  logic                      to_slow_i,
    input  logic signed [DRIFT_W-1:0] drift_i,
    input  logic [CNT_W-1:0]          elapsed_i,
    output logic signed [DRIFT_W-1:0] drift_o,
    output logic [CNT_W-1:0]          budget_o
);
    localparam int PAD = DRIFT_W - CNT_W - 1;
    localparam logic signed [DRIFT_W-1:0] MAX_BUDGET = DRIFT_W'((64'd1 << CNT_W) - 1);

    logic signed [DRIFT_W-1:0] used;
    logic signed [DRIFT_W-1:0] cand;
    logic [CNT_W:0]            used_raw;

    assign used_raw = {1'b0, elapsed_i} + 1'b1;
    assign used     = $signed({{PAD{1'b0}}, used_raw});

    always_comb begin
        if (to_slow_i) begin
            drift_o = drift_i + used;
            cand    = drift_o >>> 1;
        end else begin
            drift_o = drift_i - (used <<< 1);
            cand    = drift_o + DRIFT_W'(SLICE);
        end
        if (cand < 1) begin
            budget_o = CNT_W'(1);
        end else if (cand > MAX_BUDGET) begin
            budget_o = MAX_BUDGET[CNT_W-1:0];
        end else begin
            budget_o = cand[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/slice_arbiter.sv
module slice_arbiter #(
    parameter int CNT_W   = 24,
    parameter int DRIFT_W = 32,
    parameter int SLICE   = 2048
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_i,
    output logic [1:0]                core_sel_o,
    output logic [CNT_W-1:0]          budget_o,
    output logic signed [DRIFT_W-1:0] drift_o,
    output logic                      handover_o
);
    import slice_pkg::*;

    sched_state_t              state_q, state_d;
    logic [CNT_W-1:0]          budget_q;
    logic signed [DRIFT_W-1:0] drift_q;
    logic                      handover_q;
    logic [CNT_W-1:0]          elapsed;
    logic                      hit;
    logic signed [DRIFT_W-1:0] drift_nx;
    logic [CNT_W-1:0]          budget_nx;

    slice_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .limit_i   (budget_q),
        .elapsed_o (elapsed),
        .hit_o     (hit)
    );

    slice_budget_calc #(.CNT_W(CNT_W), .DRIFT_W(DRIFT_W), .SLICE(SLICE)) u_calc (
        .to_slow_i (state_q == ST_FAST),
        .drift_i   (drift_q),
        .elapsed_i (elapsed),
        .drift_o   (drift_nx),
        .budget_o  (budget_nx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAST: if (hit) state_d = ST_SLOW;   // T_TO_SLOW
            ST_SLOW: if (hit) state_d = ST_FAST;   // T_TO_FAST
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FAST;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drift_q    <= '0;
            budget_q   <= CNT_W'(SLICE);
            handover_q <= 1'b0;
        end else begin
            handover_q <= hit;
            if (hit) begin
                drift_q  <= drift_nx;
                budget_q <= budget_nx;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FAST: core_sel_o = 2'b01;
            ST_SLOW: core_sel_o = 2'b10;
        endcase
    end

    assign budget_o   = budget_q;
    assign drift_o    = drift_q;
    assign handover_o = handover_q;

    // R2
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(core_sel_o) == 1);
    // R6
    a_r6_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        handover_o |-> (core_sel_o != $past(core_sel_o)));
    // R7
    a_r7_idle_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> (!handover_o && $stable(core_sel_o)));
    // R8
    a_r8_budget_min: assert property (@(posedge clk) disable iff (!rst_n)
        budget_o != '0);
    // R9
    a_r9_steady_in_slice: assert property (@(posedge clk) disable iff (!rst_n)
        !handover_o |-> ($stable(drift_o) && $stable(budget_o)));
endmodule

// File: tb/tb_slice_arbiter.sv
module tb_slice_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int SLICE = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [1:0]  core_sel;
    logic [23:0] budget;
    logic signed [31:0] drift;
    logic        handover;

    int checks = 0;
    int fails = 0;
    longint m_drift = 0;
    longint m_budget = SLICE;

    slice_arbiter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .core_sel_o (core_sel),
        .budget_o   (budget),
        .drift_o    (drift),
        .handover_o (handover)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit a);
        @(negedge clk);
        step = a;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(0);
        drive(0);
        rst_n = 1'b1;
        drive(0);
        m_drift = 0;
        m_budget = SLICE;
    endtask

    task automatic check_reset_state();
        chk(core_sel == 2'b01, "R1 core_sel", core_sel, 1);
        chk(drift == 0, "R1 drift", drift, 0);
        chk(budget == SLICE, "R1 budget", budget, SLICE);
        chk(handover == 1'b0, "R1 handover", handover, 0);
    endtask

    // Run n strobes, optionally with a gap after each; count early handovers
    task automatic strobes(input int n, input int gap, output int early);
        early = 0;
        for (int i = 0; i < n; i++) begin
            drive(1);
            for (int g = 0; g < gap; g++) begin
                drive(0);
                if (handover) early++;
            end
        end
    endtask

    task automatic expect_switch(input bit to_slow, input longint e);
        if (to_slow) begin
            m_drift = m_drift + e;
            m_budget = m_drift >>> 1;
        end else begin
            m_drift = m_drift - 2 * e;
            m_budget = m_drift + SLICE;
        end
        if (m_budget < 1) m_budget = 1;
    endtask

    task automatic full_slice(input bit to_slow, input int gap, input string tag);
        int early;
        longint e = m_budget;
        logic [1:0] want = to_slow ? 2'b10 : 2'b01;
        strobes(int'(e) - 1, gap, early);
        drive(0);
        chk(early == 0 && handover == 0, {tag, " R3 no early handover"}, early, 0);
        chk(core_sel != want, {tag, " R3 still old core one short"}, core_sel, want ^ 2'b11);
        drive(1);
        drive(0);
        expect_switch(to_slow, e);
        chk(handover == 1'b1, {tag, " R6 handover high"}, handover, 1);
        chk(core_sel == want, {tag, " R3 new core"}, core_sel, want);
        chk(drift == m_drift, to_slow ? {tag, " R4 drift"} : {tag, " R5 drift"}, drift, m_drift);
        chk(budget == m_budget, to_slow ? {tag, " R4 budget"} : {tag, " R5 budget"}, budget, m_budget);
        chk(budget >= 1, {tag, " R8 budget nonzero"}, budget, 1);
        drive(0);
        chk(handover == 1'b0, {tag, " R6 handover one clock"}, handover, 0);
    endtask

    task automatic test_idle_hold();
        int early;
        int bad = 0;
        logic [1:0] sel0;
        logic signed [31:0] d0;
        logic [23:0] b0;
        strobes(100, 0, early);
        drive(0);
        sel0 = core_sel; d0 = drift; b0 = budget;
        for (int i = 0; i < 60; i++) begin
            drive(0);
            if (handover || core_sel != sel0) bad++;
        end
        chk(bad == 0, "R7 idle keeps core", bad, 0);
        chk(drift == d0 && budget == b0, "R9 steady during slice", drift, d0);
        begin
            longint e = m_budget;
            strobes(int'(e) - 101, 0, early);
            drive(0);
            chk(handover == 0 && early == 0, "R7 count held across idle", handover, 0);
            drive(1);
            drive(0);
            expect_switch(1'b1, e);
            chk(handover == 1 && core_sel == 2'b10, "R3 switch after held count", core_sel, 2);
            chk(drift == m_drift, "R4 drift after idle", drift, m_drift);
        end
    endtask

    task automatic test_reset_mid();
        int early;
        strobes(500, 0, early);
        do_reset();
        check_reset_state();
        full_slice(1'b1, 0, "post-reset");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        check_reset_state();
        full_slice(1'b1, 0, "fast->slow");
        full_slice(1'b0, 1, "slow->fast gapped");
        full_slice(1'b1, 2, "fast->slow gapped");
        full_slice(1'b0, 0, "slow->fast");
        test_idle_hold();
        full_slice(1'b0, 0, "back to fast");
        test_reset_mid();
        chk($countones(core_sel) == 1, "R2 one-hot", core_sel, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule